// File: doc/BRIEF.md
# Weighted Chi-Square Template Classifier

This block labels one measured histogram feature vector with the class whose stored template lies closest to it. Closeness is a weighted chi-square distance. Each element adds `w * (S - M)^2 / (S + M)`, where S is the measured bin count, M is the template bin count, and w is a weight chosen by the region (cell) that the bin belongs to. Regions rich in features can therefore count more than flat ones. A small table of reciprocals does the division, so the datapath has no divider.

The host first fills the template and weight register arrays through a one-word-per-cycle write port. It then streams the feature vector one element per cycle, with each element's cell index beside it. When the last element arrives, the block buffers the vector and makes one full pass over it for each template in turn. It accumulates each distance and tracks the smallest one. At the end it raises `done` for one cycle and presents the winning class index and its distance. The defaults are a 16-element vector (4 cells of 4 bins) and seven classes. The parameters scale to a full-size feature vector, for example 42 cells of 59 bins for 2478 elements. The storage grows with N_CLASS times the vector length.

Top module: `chisq_template_classifier`

## Requirements
- R1: The reported distance is the exact sum over all elements of `w[cell] * (S-M)^2 * floor(65536/(S+M))`. This is a fixed-point value with 16 fractional bits. The accumulator is wide enough that it never wraps.
- R2: The reciprocal comes from a lookup of `floor(65536/k)` for k = S+M. An element with S+M = 0 adds nothing.
- R3: The weight of an element is taken from the cell index streamed beside that element, not from the element's position. A cell whose weight is 0 adds nothing.
- R4: `best_class` is the index of the template with the smallest distance among the N_CLASS templates. `best_dist` is that distance.
- R5: When distances tie, the lowest class index wins.
- R6: Elements presented with `feat_valid` high are stored in arrival order as positions 0 to N_ELEM-1. Accepting the N_ELEM-th element starts the classification.
- R7: `done` is high for exactly one cycle. It rises N_CLASS*N_ELEM clock edges after the edge that accepted the final element.
- R8: `feat_valid` is ignored while a classification is running. Such elements neither alter the result nor start a new vector.
- R9: `best_class` and `best_dist` change only together with a `done` pulse. They hold their values at all other times, including during the next run.
- R10: During and after reset, `done`, `best_class` and `best_dist` are 0.
- R11: A write with `cfg_wgt`=0 stores `cfg_data` as element `cfg_addr` of template `cfg_cls`. A write with `cfg_wgt`=1 stores the low WGT_W bits of `cfg_data` as the weight of cell `cfg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wgt | input | 1 | 1 selects a weight write, 0 selects a template write |
| cfg_cls | input | CLS_W | Template class for a template write |
| cfg_addr | input | IDX_W | Element index (template write) or cell index (weight write) |
| cfg_data | input | DATA_W | Write data |
| feat_valid | input | 1 | Feature element valid |
| feat_bin | input | DATA_W | Measured bin count S |
| feat_cell | input | CELL_W | Cell index of this element |
| done | output | 1 | One-cycle result strobe |
| best_class | output | CLS_W | Winning class index |
| best_dist | output | DIST_W | Winning distance, 16 fractional bits |

## Verification
All results arrive N_CLASS*N_ELEM edges after the edge that accepts the final element. The bench counts rising edges from that edge and reads `done` on each falling edge. It expects the pulse on count 112 for the defaults, and it checks one edge later that the pulse has ended. Class and distance are read at the falling edge where `done` is first seen. The hold checks read the outputs midway through a later scan and several idle cycles after a pulse, never near an edge.

// File: rtl/chi_pkg.sv
`timescale 1ns/1ps
package chi_pkg;
  // Fractional bits of the reciprocal and of the reported distance
  localparam int unsigned RECIP_FRAC = 16;

  typedef enum logic [0:0] {
    ST_COLLECT = 1'b0,
    ST_SCAN    = 1'b1
  } scan_state_e;
endpackage

// File: rtl/chi_recip_rom.sv
`timescale 1ns/1ps
module chi_recip_rom #(
  parameter int unsigned SUM_W = 9,
  parameter int unsigned FRAC  = 16,
  parameter int unsigned OUT_W = 17
) (
  input  logic [SUM_W-1:0] sum_i,
  output logic [OUT_W-1:0] recip_o
);
  localparam int unsigned DEPTH = 1 << SUM_W;

  logic [OUT_W-1:0] rom [DEPTH];

  // Entry 0 is forced to zero so that an empty pair contributes nothing
  assign rom[0] = '0;
  for (genvar k = 1; k < DEPTH; k++) begin : g_entry
    localparam longint unsigned VAL = (64'd1 << FRAC) / k;
    assign rom[k] = OUT_W'(VAL);
  end

  assign recip_o = rom[sum_i];
endmodule

// File: rtl/chi_term.sv
`timescale 1ns/1ps
module chi_term
  import chi_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WGT_W  = 4,
  parameter int unsigned TERM_W = 2*DATA_W + RECIP_FRAC + 1 + WGT_W
) (
  input  logic [DATA_W-1:0] meas_i,
  input  logic [DATA_W-1:0] tmpl_i,
  input  logic [WGT_W-1:0]  wgt_i,
  output logic [TERM_W-1:0] term_o
);
  localparam int unsigned SUM_W   = DATA_W + 1;
  localparam int unsigned RECIP_W = RECIP_FRAC + 1;

  logic [SUM_W-1:0]    pair_sum;
  logic [DATA_W-1:0]   abs_diff;
  logic [2*DATA_W-1:0] diff_sq;
  logic [RECIP_W-1:0]  recip;

  always_comb begin
    pair_sum = {1'b0, meas_i} + {1'b0, tmpl_i};
    abs_diff = (meas_i >= tmpl_i) ? (meas_i - tmpl_i) : (tmpl_i - meas_i);
    diff_sq  = (2*DATA_W)'(abs_diff) * (2*DATA_W)'(abs_diff);
  end

  chi_recip_rom #(
    .SUM_W (SUM_W),
    .FRAC  (RECIP_FRAC),
    .OUT_W (RECIP_W)
  ) u_recip (
    .sum_i   (pair_sum),
    .recip_o (recip)
  );

  assign term_o = TERM_W'(wgt_i) * TERM_W'(diff_sq) * TERM_W'(recip);
endmodule

// File: rtl/chi_argmin.sv
`timescale 1ns/1ps
module chi_argmin #(
  parameter int unsigned CLS_W  = 3,
  parameter int unsigned DIST_W = 42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_valid,
  input  logic              cand_first,
  input  logic [CLS_W-1:0]  cand_cls,
  input  logic [DIST_W-1:0] cand_dist,
  output logic [CLS_W-1:0]  win_cls_o,
  output logic [DIST_W-1:0] win_dist_o
);
  logic [CLS_W-1:0]  lead_cls_q, lead_cls_d;
  logic [DIST_W-1:0] lead_dist_q, lead_dist_d;
  logic              take;

  // Strict comparison: an equal later class never displaces an earlier one
  always_comb begin
    take        = cand_valid && (cand_first || (cand_dist < lead_dist_q));
    lead_cls_d  = take ? cand_cls  : lead_cls_q;
    lead_dist_d = take ? cand_dist : lead_dist_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_cls_q  <= '0;
      lead_dist_q <= '0;
    end else if (cand_valid) begin
      lead_cls_q  <= lead_cls_d;
      lead_dist_q <= lead_dist_d;
    end
  end

  assign win_cls_o  = lead_cls_d;
  assign win_dist_o = lead_dist_d;
endmodule

// File: rtl/chisq_template_classifier.sv
`timescale 1ns/1ps
module chisq_template_classifier
  import chi_pkg::*;
#(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned WGT_W         = 4,
  parameter int unsigned N_CELL        = 4,
  parameter int unsigned BINS_PER_CELL = 4,
  parameter int unsigned N_CLASS       = 7,
  localparam int unsigned N_ELEM = N_CELL * BINS_PER_CELL,
  localparam int unsigned IDX_W  = (N_ELEM  > 1) ? $clog2(N_ELEM)  : 1,
  localparam int unsigned CELL_W = (N_CELL  > 1) ? $clog2(N_CELL)  : 1,
  localparam int unsigned CLS_W  = (N_CLASS > 1) ? $clog2(N_CLASS) : 1,
  localparam int unsigned TERM_W = 2*DATA_W + RECIP_FRAC + 1 + WGT_W,
  localparam int unsigned DIST_W = TERM_W + $clog2(N_ELEM + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_wgt,
  input  logic [CLS_W-1:0]  cfg_cls,
  input  logic [IDX_W-1:0]  cfg_addr,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              feat_valid,
  input  logic [DATA_W-1:0] feat_bin,
  input  logic [CELL_W-1:0] feat_cell,
  output logic              done,
  output logic [CLS_W-1:0]  best_class,
  output logic [DIST_W-1:0] best_dist
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ELEM - 1);
  localparam logic [CLS_W-1:0] LAST_CLS = CLS_W'(N_CLASS - 1);

  // ---------------------------------------------------------------
  // Reset: asserted asynchronously, released on the clock
  // ---------------------------------------------------------------
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // ---------------------------------------------------------------
  // Storage: templates, cell weights, buffered measured vector
  // ---------------------------------------------------------------
  logic [DATA_W-1:0] tmpl_q [N_CLASS][N_ELEM];
  logic [WGT_W-1:0]  wgt_q  [N_CELL];
  logic [DATA_W-1:0] meas_q [N_ELEM];
  logic [CELL_W-1:0] tag_q  [N_ELEM];

  always_ff @(posedge clk) begin
    for (int c = 0; c < N_CLASS; c++) begin
      for (int e = 0; e < N_ELEM; e++) begin
        if (cfg_we && !cfg_wgt && (cfg_cls == CLS_W'(c)) && (cfg_addr == IDX_W'(e)))
          tmpl_q[c][e] <= cfg_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < N_CELL; k++) begin
      if (cfg_we && cfg_wgt && (cfg_addr == IDX_W'(k)))
        wgt_q[k] <= cfg_data[WGT_W-1:0];
    end
  end

  // ---------------------------------------------------------------
  // Control state
  // ---------------------------------------------------------------
  scan_state_e       state_q, state_d;
  logic [IDX_W-1:0]  wr_idx_q, wr_idx_d;
  logic [IDX_W-1:0]  rd_idx_q, rd_idx_d;
  logic [CLS_W-1:0]  cls_q, cls_d;
  logic [DIST_W-1:0] acc_q, acc_d;
  logic              done_q, done_d;
  logic [CLS_W-1:0]  res_cls_q, res_cls_d;
  logic [DIST_W-1:0] res_dist_q, res_dist_d;
  logic              meas_we;
  logic              scan_busy;

  always_ff @(posedge clk) begin
    if (meas_we) begin
      meas_q[wr_idx_q] <= feat_bin;
      tag_q[wr_idx_q]  <= feat_cell;
    end
  end

  // ---------------------------------------------------------------
  // Datapath: one element term per cycle, running sum, minimum
  // ---------------------------------------------------------------
  logic [TERM_W-1:0] term;
  logic [DIST_W-1:0] acc_sum;
  logic              pass_end;
  logic [CLS_W-1:0]  win_cls;
  logic [DIST_W-1:0] win_dist;

  chi_term #(
    .DATA_W (DATA_W),
    .WGT_W  (WGT_W),
    .TERM_W (TERM_W)
  ) u_term (
    .meas_i (meas_q[rd_idx_q]),
    .tmpl_i (tmpl_q[cls_q][rd_idx_q]),
    .wgt_i  (wgt_q[tag_q[rd_idx_q]]),
    .term_o (term)
  );

  assign scan_busy = (state_q == ST_SCAN);
  assign acc_sum   = acc_q + DIST_W'(term);
  assign pass_end  = scan_busy && (rd_idx_q == LAST_IDX);

  chi_argmin #(
    .CLS_W  (CLS_W),
    .DIST_W (DIST_W)
  ) u_argmin (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cand_valid (pass_end),
    .cand_first (cls_q == '0),
    .cand_cls   (cls_q),
    .cand_dist  (acc_sum),
    .win_cls_o  (win_cls),
    .win_dist_o (win_dist)
  );

  // ---------------------------------------------------------------
  // Next-state logic
  // ---------------------------------------------------------------
  always_comb begin
    state_d    = state_q;
    wr_idx_d   = wr_idx_q;
    rd_idx_d   = rd_idx_q;
    cls_d      = cls_q;
    acc_d      = acc_q;
    done_d     = 1'b0;
    res_cls_d  = res_cls_q;
    res_dist_d = res_dist_q;
    meas_we    = 1'b0;

    unique case (state_q)
      ST_COLLECT: begin
        if (feat_valid) begin
          meas_we = 1'b1;
          if (wr_idx_q == LAST_IDX) begin
            wr_idx_d = '0;
            rd_idx_d = '0;
            cls_d    = '0;
            acc_d    = '0;
            state_d  = ST_SCAN;
          end else begin
            wr_idx_d = wr_idx_q + 1'b1;
          end
        end
      end
      ST_SCAN: begin
        if (rd_idx_q == LAST_IDX) begin
          rd_idx_d = '0;
          acc_d    = '0;
          if (cls_q == LAST_CLS) begin
            state_d    = ST_COLLECT;
            done_d     = 1'b1;
            res_cls_d  = win_cls;
            res_dist_d = win_dist;
          end else begin
            cls_d = cls_q + 1'b1;
          end
        end else begin
          rd_idx_d = rd_idx_q + 1'b1;
          acc_d    = acc_sum;
        end
      end
      default: state_d = ST_COLLECT;
    endcase
  end

  // ---------------------------------------------------------------
  // Registers
  // ---------------------------------------------------------------
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q    <= ST_COLLECT;
      wr_idx_q   <= '0;
      rd_idx_q   <= '0;
      cls_q      <= '0;
      acc_q      <= '0;
      done_q     <= 1'b0;
      res_cls_q  <= '0;
      res_dist_q <= '0;
    end else begin
      state_q    <= state_d;
      wr_idx_q   <= wr_idx_d;
      rd_idx_q   <= rd_idx_d;
      cls_q      <= cls_d;
      acc_q      <= acc_d;
      done_q     <= done_d;
      res_cls_q  <= res_cls_d;
      res_dist_q <= res_dist_d;
    end
  end

  assign done       = done_q;
  assign best_class = res_cls_q;
  assign best_dist  = res_dist_q;
endmodule

// File: rtl/chisq_checker.sv
`timescale 1ns/1ps
module chisq_checker #(
  parameter int unsigned N_CLASS = 7,
  parameter int unsigned N_ELEM  = 16,
  parameter int unsigned CLS_W   = 3,
  parameter int unsigned DIST_W  = 42
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              scan_busy,
  input logic [CLS_W-1:0]  best_class,
  input logic [DIST_W-1:0] best_dist
);
  localparam int unsigned TOTAL = N_CLASS * N_ELEM;
  localparam int unsigned CNT_W = $clog2(TOTAL + 1) + 1;

  // Length of the current scan, counted without any deep $past
  logic [CNT_W-1:0] scan_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         scan_cnt_q <= '0;
    else if (scan_busy) scan_cnt_q <= scan_cnt_q + CNT_W'(1);
    else                scan_cnt_q <= '0;
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (scan_cnt_q == CNT_W'(TOTAL)));

  assert_no_done_in_scan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_busy |-> !done);

  assert_class_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (best_class <= CLS_W'(N_CLASS - 1)));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(best_class) && $stable(best_dist)));
endmodule

bind chisq_template_classifier chisq_checker #(
  .N_CLASS (N_CLASS),
  .N_ELEM  (N_ELEM),
  .CLS_W   (CLS_W),
  .DIST_W  (DIST_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done       (done),
  .scan_busy  (scan_busy),
  .best_class (best_class),
  .best_dist  (best_dist)
);

// File: tb/chisq_template_classifier_bench.sv
`timescale 1ns/1ps
module chisq_template_classifier_bench;
  localparam int K   = 7;
  localparam int N   = 16;
  localparam int NC  = 4;
  localparam int BPC = 4;
  localparam int LAT = K * N;

  // {target class, offset added to element 5}
  localparam int unsigned VEC_TAB [6][2] = '{
    '{0, 0}, '{3, 1}, '{6, 0}, '{1, 1}, '{5, 0}, '{2, 1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_wgt;
  logic [2:0]  cfg_cls;
  logic [3:0]  cfg_addr;
  logic [7:0]  cfg_data;
  logic        feat_valid;
  logic [7:0]  feat_bin;
  logic [1:0]  feat_cell;
  logic        done;
  logic [2:0]  best_class;
  logic [41:0] best_dist;

  int unsigned t_m [K][N];
  int unsigned w_m [NC];
  int unsigned s_m [N];
  int unsigned c_m [N];
  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  chisq_template_classifier u_chisq_template_classifier (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wgt(cfg_wgt), .cfg_cls(cfg_cls),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .feat_valid(feat_valid), .feat_bin(feat_bin),
    .feat_cell(feat_cell), .done(done), .best_class(best_class), .best_dist(best_dist)
  );

  task automatic check(input bit ok, input string tag, input longint unsigned act,
                       input longint unsigned exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint unsigned model_dist(int c);
    longint unsigned acc = 0;
    for (int i = 0; i < N; i++) begin
      longint unsigned sm, d;
      sm = longint'(s_m[i]) + longint'(t_m[c][i]);
      d  = (s_m[i] >= t_m[c][i]) ? longint'(s_m[i] - t_m[c][i]) : longint'(t_m[c][i] - s_m[i]);
      if (sm != 0) acc += longint'(w_m[c_m[i]]) * d * d * (longint'(65536) / sm);
    end
    return acc;
  endfunction

  task automatic set_base();
    for (int c = 0; c < K; c++)
      for (int i = 0; i < N; i++)
        t_m[c][i] = 20 + (c*37 + i*13 + c*i*3 + 9) % 200;
    w_m = '{1, 2, 3, 5};
    for (int i = 0; i < N; i++) c_m[i] = i / BPC;
  endtask

  task automatic wr_cfg(input bit wgt, input int cls, input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wgt = wgt; cfg_cls = 3'(cls); cfg_addr = 4'(addr); cfg_data = 8'(data);
  endtask

  task automatic load_all();
    for (int c = 0; c < K; c++)
      for (int i = 0; i < N; i++) wr_cfg(1'b0, c, i, int'(t_m[c][i]));
    for (int k = 0; k < NC; k++) wr_cfg(1'b1, 0, k, int'(w_m[k]));
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_vec(input bit junk, input bit hold_chk, output int lat, output bit one_cycle);
    logic [2:0]  pc;
    logic [41:0] pd;
    pc = best_class;
    pd = best_dist;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      feat_valid = 1'b1; feat_bin = 8'(s_m[i]); feat_cell = 2'(c_m[i]);
    end
    @(posedge clk);
    @(negedge clk);
    feat_valid = junk; feat_bin = 8'hA5; feat_cell = 2'd0;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (!done && hold_chk && lat == LAT/2)
        check(best_class == pc && best_dist == pd, "R9 outputs hold during scan",
              longint'(best_dist), longint'(pd));
      if (!done && junk) begin feat_bin = 8'(lat * 7); feat_cell = 2'(lat); end
    end while (!done && lat < LAT + 20);
    feat_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    one_cycle = !done;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R7 actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int lat;
    bit oc;
    longint unsigned exp_d;
    logic [2:0]  hc;
    logic [41:0] hd;

    rst_n = 1'b0; cfg_we = 1'b0; cfg_wgt = 1'b0; cfg_cls = '0; cfg_addr = '0; cfg_data = '0;
    feat_valid = 1'b0; feat_bin = '0; feat_cell = '0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R10 done in reset", longint'(done), 0);
    check(best_class == '0, "R10 class in reset", longint'(best_class), 0);
    check(best_dist == '0, "R10 dist in reset", longint'(best_dist), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(done == 1'b0 && best_dist == '0, "R10 idle after release", longint'(best_dist), 0);

    // Table of vectors: each is a template, possibly nudged by one count
    set_base();
    load_all();
    for (int e = 0; e < 6; e++) begin
      int tgt;
      tgt = int'(VEC_TAB[e][0]);
      for (int i = 0; i < N; i++) s_m[i] = t_m[tgt][i] + ((i == 5) ? VEC_TAB[e][1] : 0);
      exp_d = model_dist(tgt);
      run_vec(1'b0, e == 1, lat, oc);
      check(lat == LAT, "R7 done latency", longint'(lat), longint'(LAT));
      check(best_class == 3'(tgt), "R4 R11 winning class", longint'(best_class), longint'(tgt));
      check(best_dist == 42'(exp_d), "R1 R6 winning distance", longint'(best_dist), exp_d);
      check(oc, "R7 single cycle done", longint'(!oc), 0);
    end

    // R9: idle hold
    hc = best_class; hd = best_dist;
    repeat (6) @(negedge clk);
    check(best_class == hc && best_dist == hd, "R9 outputs hold when idle",
          longint'(best_dist), longint'(hd));

    // R5: two identical templates, lower index wins
    for (int i = 0; i < N; i++) begin t_m[2][i] = t_m[5][i]; s_m[i] = t_m[5][i]; end
    load_all();
    run_vec(1'b0, 1'b0, lat, oc);
    check(best_class == 3'd2, "R5 tie lowest index", longint'(best_class), 2);
    check(best_dist == '0, "R5 tie distance", longint'(best_dist), 0);

    // R2: empty pairs add nothing
    set_base();
    for (int i = 0; i < N; i++) begin t_m[4][i] = 0; s_m[i] = 0; end
    load_all();
    run_vec(1'b0, 1'b0, lat, oc);
    check(best_class == 3'd4, "R2 zero-sum class", longint'(best_class), 4);
    check(best_dist == '0, "R2 zero-sum distance", longint'(best_dist), 0);

    // R2: reciprocal values at k=255, 1, 0, 5 (all templates equal, so R5 too)
    for (int i = 0; i < N; i++) s_m[i] = 50;
    s_m[0] = 255; s_m[1] = 1; s_m[2] = 0; s_m[3] = 3;
    for (int c = 0; c < K; c++)
      for (int i = 0; i < N; i++) t_m[c][i] = s_m[i];
    for (int c = 0; c < K; c++) begin t_m[c][0] = 0; t_m[c][1] = 0; t_m[c][3] = 2; end
    load_all();
    run_vec(1'b0, 1'b0, lat, oc);
    check(best_dist == 42'd16790068, "R2 reciprocal lookup", longint'(best_dist), 16790068);
    check(best_dist == 42'(model_dist(0)), "R1 reciprocal model", longint'(best_dist), model_dist(0));
    check(best_class == 3'd0, "R5 all-equal tie", longint'(best_class), 0);

    // R3: weight follows the streamed tag; a zero-weight cell is masked
    set_base();
    w_m[1] = 0;
    for (int i = 0; i < N; i++) s_m[i] = t_m[3][i];
    for (int i = 4; i < 8; i++) s_m[i] = 0;
    s_m[0] = 0; c_m[0] = 1;
    load_all();
    run_vec(1'b0, 1'b0, lat, oc);
    check(best_class == 3'd3, "R3 zero weight class", longint'(best_class), 3);
    check(best_dist == '0, "R3 zero weight distance", longint'(best_dist), 0);

    // R8: elements offered during a scan are discarded
    set_base();
    load_all();
    for (int i = 0; i < N; i++) s_m[i] = t_m[0][i];
    s_m[9] = s_m[9] + 1;
    exp_d = model_dist(0);
    run_vec(1'b1, 1'b0, lat, oc);
    check(best_class == 3'd0 && best_dist == 42'(exp_d), "R8 junk during scan",
          longint'(best_dist), exp_d);
    for (int i = 0; i < N; i++) s_m[i] = t_m[6][i];
    exp_d = model_dist(6);
    run_vec(1'b0, 1'b0, lat, oc);
    check(lat == LAT && best_class == 3'd6, "R8 R6 next vector aligned", longint'(best_class), 6);
    check(best_dist == 42'(exp_d), "R8 next vector distance", longint'(best_dist), exp_d);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule